// File: doc/BRIEF.md
# Configuration Window Decoder

This block sits between a processor memory bus and an internal configuration bus. Software places a window of power-of-two size at a base address that is aligned to that size. Any access that lands inside the window is claimed. The block subtracts the base from the address and cuts the resulting offset into a bus number, a device number, a function number and a register offset. It then issues the access on the configuration side as a read or a write of 1, 2 or 4 bytes.

The configuration side answers with a completion that carries a presence flag. A function that is absent does not fail the access. A read from it returns all ones, and a write to it is simply completed. The window can be moved, resized or switched off while the block is running. Every update command first tears the old mapping down. A new window is installed only when the enable input is set and the requested size is legal. An illegal size raises a one-cycle error and leaves the window off.

Top module: `cfg_window_decoder`

## Requirements
- R1: After reset the window is unmapped (`win_mapped`=0), and `map_err`, `tgt_req_valid` and `cpu_rsp_valid` are low while `cpu_ready` is high.
- R2: The register offset `tgt_reg` equals bits 11..0 of (address − base).
- R3: Offset bits 19..15 appear as `tgt_dev` and offset bits 14..12 appear as `tgt_fn`.
- R4: Offset bits 28..20 appear as the 9-bit `tgt_bus`.
- R5: A width code of 1, 2 or 4 reaches `tgt_len` unchanged. Any other code is not claimed: no target request and no response follow.
- R6: A read whose completion has `tgt_present`=0 returns 32'hFFFF_FFFF on `cpu_rdata`.
- R7: A write to an absent function completes with a single response carrying `cpu_rdata`=0, and the window mapping is left unchanged.
- R8: While the window is unmapped, no access is claimed.
- R9: An access is claimed only when base ≤ address < base + size. Addresses outside that range produce no request and no response.
- R10: A map request is accepted only for a power-of-two size from 2^20 to 2^28. Any other size pulses `map_err` for exactly one cycle and leaves `win_mapped`=0.
- R11: A `map_upd` pulse always unmaps the window. It installs the new base and size, visible one cycle later, only when `map_en`=1 and the size is legal.
- R12: An accepted access raises `tgt_req_valid` in the next cycle and holds the request stable until `tgt_rsp_valid`. `cpu_rsp_valid` is high for exactly the one cycle after the completion, and `cpu_ready` is high only when no access is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_upd | input | 1 | Window update command (one-cycle pulse) |
| map_en | input | 1 | Map a new window on this update |
| map_base | input | 32 | New window base, aligned to the size |
| map_size | input | 32 | New window size in bytes |
| map_err | output | 1 | One-cycle pulse: the size was rejected |
| win_mapped | output | 1 | Window currently mapped |
| cpu_req | input | 1 | Access request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor address |
| cpu_len | input | 3 | Width in bytes (1, 2 or 4) |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Block idle, can take an access |
| cpu_rsp_valid | output | 1 | Access completed (one cycle) |
| cpu_rdata | output | 32 | Read data (0 for writes) |
| tgt_req_valid | output | 1 | Configuration request pending |
| tgt_we | output | 1 | Request is a write |
| tgt_bus | output | 9 | Bus number |
| tgt_dev | output | 5 | Device number |
| tgt_fn | output | 3 | Function number |
| tgt_reg | output | 12 | Register offset within the function |
| tgt_len | output | 3 | Width in bytes |
| tgt_wdata | output | 32 | Write data |
| tgt_rsp_valid | input | 1 | Target completion |
| tgt_present | input | 1 | Addressed function exists |
| tgt_rdata | input | 32 | Target read data |

## Verification
The assertions check these properties on every cycle:
- Forwarded widths are always legal.
- A request never starts unless the window was mapped.
- A request stays stable until its completion.
- The response follows a completion by exactly one cycle and lasts one cycle.
- An absent read yields all ones.
- An error pulse always coincides with the unmapped state.

The arithmetic cannot be shown by a property and is left to the bench scenarios:
- the field split at several offsets and window placements;
- the window edges after relocation;
- the rejection of each kind of illegal size;
- the silent drop of illegal widths and of accesses that miss the window.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
    localparam int REG_W   = 12;
    localparam int FN_W    = 3;
    localparam int DEV_W   = 5;
    localparam int BUS_W   = 9;
    localparam int FN_LSB  = REG_W;
    localparam int DEV_LSB = FN_LSB + FN_W;
    localparam int BUS_LSB = DEV_LSB + DEV_W;
    localparam int TOP_BIT = BUS_LSB + BUS_W - 1;

    typedef enum logic [1:0] {XS_IDLE, XS_WAIT, XS_RESP} xact_state_e;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [REG_W-1:0] reg_off;
    } cfg_target_t;
endpackage

// File: rtl/cfgw_map_ctrl.sv
module cfgw_map_ctrl #(
    parameter int ADDR_W = 32,
    parameter int MIN_LG = 20,
    parameter int MAX_LG = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              en,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] size_in,
    output logic              mapped,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] size,
    output logic              err
);
    localparam int N_SIZES = MAX_LG - MIN_LG + 1;

    typedef struct packed {
        logic              mapped;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] size;
        logic              err;
    } map_t;

    map_t map_d, map_q;
    logic [N_SIZES-1:0] size_match;

    for (genvar k = 0; k < N_SIZES; k++) begin : g_size
        assign size_match[k] = (size_in == (ADDR_W'(1) << (MIN_LG + k)));
    end

    always_comb begin
        map_d     = map_q;
        map_d.err = 1'b0;
        if (upd) begin
            map_d.mapped = 1'b0;
            if (en) begin
                if (|size_match) begin
                    map_d.mapped = 1'b1;
                    map_d.base   = base_in;
                    map_d.size   = size_in;
                end else begin
                    map_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    assign mapped = map_q.mapped;
    assign base   = map_q.base;
    assign size   = map_q.size;
    assign err    = map_q.err;
endmodule

// File: rtl/cfgw_field_split.sv
module cfgw_field_split
    import cfgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 3
) (
    input  logic              mapped,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] size,
    input  logic [LEN_W-1:0]  len,
    output logic              claim,
    output cfg_target_t       fields
);
    logic [ADDR_W-1:0] offset;
    logic              len_ok;

    always_comb begin
        offset  = addr - base;
        len_ok  = (len == LEN_W'(1)) || (len == LEN_W'(2)) || (len == LEN_W'(4));
        claim   = mapped && len_ok && (offset < size);
        fields.reg_off = offset[FN_LSB-1:0];
        fields.fn      = offset[DEV_LSB-1:FN_LSB];
        fields.dev     = offset[BUS_LSB-1:DEV_LSB];
        fields.bus     = offset[TOP_BIT:BUS_LSB];
    end
endmodule

// File: rtl/cfgw_xact.sv
module cfgw_xact
    import cfgw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [LEN_W-1:0]  cpu_len,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              claim,
    input  cfg_target_t       fields,
    output logic              cpu_ready,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              tgt_req_valid,
    output logic              tgt_we,
    output cfg_target_t       tgt_fields,
    output logic [LEN_W-1:0]  tgt_len,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic              tgt_rsp_valid,
    input  logic              tgt_present,
    input  logic [DATA_W-1:0] tgt_rdata
);
    typedef struct packed {
        xact_state_e       st;
        logic              we;
        cfg_target_t       tgt;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } xact_t;

    xact_t x_d, x_q;

    always_comb begin
        x_d = x_q;
        case (x_q.st)
            XS_IDLE: begin
                if (cpu_req && claim) begin
                    x_d.st    = XS_WAIT;
                    x_d.we    = cpu_we;
                    x_d.tgt   = fields;
                    x_d.len   = cpu_len;
                    x_d.wdata = cpu_wdata;
                end
            end
            XS_WAIT: begin
                if (tgt_rsp_valid) begin
                    x_d.st = XS_RESP;
                    if (x_q.we)           x_d.rdata = '0;
                    else if (tgt_present) x_d.rdata = tgt_rdata;
                    else                  x_d.rdata = '1;
                end
            end
            XS_RESP: x_d.st = XS_IDLE;
            default: x_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            x_q.st <= XS_IDLE;
        end else begin
            x_q <= x_d;
        end
    end

    assign cpu_ready     = (x_q.st == XS_IDLE);
    assign cpu_rsp_valid = (x_q.st == XS_RESP);
    assign cpu_rdata     = x_q.rdata;
    assign tgt_req_valid = (x_q.st == XS_WAIT);
    assign tgt_we        = x_q.we;
    assign tgt_fields    = x_q.tgt;
    assign tgt_len       = x_q.len;
    assign tgt_wdata     = x_q.wdata;
endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
    import cfgw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 3,
    parameter int MIN_LG = 20,
    parameter int MAX_LG = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_upd,
    input  logic              map_en,
    input  logic [ADDR_W-1:0] map_base,
    input  logic [ADDR_W-1:0] map_size,
    output logic              map_err,
    output logic              win_mapped,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [LEN_W-1:0]  cpu_len,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              tgt_req_valid,
    output logic              tgt_we,
    output logic [BUS_W-1:0]  tgt_bus,
    output logic [DEV_W-1:0]  tgt_dev,
    output logic [FN_W-1:0]   tgt_fn,
    output logic [REG_W-1:0]  tgt_reg,
    output logic [LEN_W-1:0]  tgt_len,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic              tgt_rsp_valid,
    input  logic              tgt_present,
    input  logic [DATA_W-1:0] tgt_rdata
);
    logic [ADDR_W-1:0] win_base, win_size;
    logic              claim;
    cfg_target_t       fields, tgt_fields;

    cfgw_map_ctrl #(.ADDR_W(ADDR_W), .MIN_LG(MIN_LG), .MAX_LG(MAX_LG)) u_map (
        .clk(clk), .rst_n(rst_n), .upd(map_upd), .en(map_en),
        .base_in(map_base), .size_in(map_size),
        .mapped(win_mapped), .base(win_base), .size(win_size), .err(map_err)
    );

    cfgw_field_split #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_split (
        .mapped(win_mapped), .addr(cpu_addr), .base(win_base), .size(win_size),
        .len(cpu_len), .claim(claim), .fields(fields)
    );

    cfgw_xact #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_xact (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_len(cpu_len), .cpu_wdata(cpu_wdata),
        .claim(claim), .fields(fields),
        .cpu_ready(cpu_ready), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rdata(cpu_rdata),
        .tgt_req_valid(tgt_req_valid), .tgt_we(tgt_we), .tgt_fields(tgt_fields),
        .tgt_len(tgt_len), .tgt_wdata(tgt_wdata),
        .tgt_rsp_valid(tgt_rsp_valid), .tgt_present(tgt_present), .tgt_rdata(tgt_rdata)
    );

    assign tgt_bus = tgt_fields.bus;
    assign tgt_dev = tgt_fields.dev;
    assign tgt_fn  = tgt_fields.fn;
    assign tgt_reg = tgt_fields.reg_off;
endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              map_err,
    input logic              win_mapped,
    input logic              cpu_rsp_valid,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              tgt_req_valid,
    input logic              tgt_we,
    input logic [8:0]        tgt_bus,
    input logic [11:0]       tgt_reg,
    input logic [LEN_W-1:0]  tgt_len,
    input logic              tgt_rsp_valid,
    input logic              tgt_present
);
    a_r5_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req_valid |-> (tgt_len == LEN_W'(1) || tgt_len == LEN_W'(2) || tgt_len == LEN_W'(4)));

    a_r8_start_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_req_valid) |-> $past(win_mapped));

    a_r10_err_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        map_err |-> !win_mapped);

    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req_valid && !tgt_rsp_valid) |=> (tgt_req_valid && $stable(tgt_bus) && $stable(tgt_reg)));

    a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req_valid && tgt_rsp_valid) |=> cpu_rsp_valid);

    a_r12_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> !cpu_rsp_valid);

    a_r6_absent_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req_valid && tgt_rsp_valid && !tgt_we && !tgt_present) |=> (cpu_rdata == '1));
endmodule

bind cfg_window_decoder cfgw_checker #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .map_err(map_err), .win_mapped(win_mapped),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rdata(cpu_rdata),
    .tgt_req_valid(tgt_req_valid), .tgt_we(tgt_we), .tgt_bus(tgt_bus),
    .tgt_reg(tgt_reg), .tgt_len(tgt_len),
    .tgt_rsp_valid(tgt_rsp_valid), .tgt_present(tgt_present)
);

// File: tb/tb_cfg_window_decoder.sv
`timescale 1ns/1ps
module tb_cfg_window_decoder;
    logic clk = 0, rst_n = 0;
    logic map_upd = 0, map_en = 0;
    logic [31:0] map_base = 0, map_size = 0;
    logic map_err, win_mapped;
    logic cpu_req = 0, cpu_we = 0;
    logic [31:0] cpu_addr = 0, cpu_wdata = 0;
    logic [2:0] cpu_len = 0;
    logic cpu_ready, cpu_rsp_valid;
    logic [31:0] cpu_rdata;
    logic tgt_req_valid, tgt_we;
    logic [8:0] tgt_bus;
    logic [4:0] tgt_dev;
    logic [2:0] tgt_fn;
    logic [11:0] tgt_reg;
    logic [2:0] tgt_len;
    logic [31:0] tgt_wdata;
    logic tgt_rsp_valid = 0, tgt_present = 0;
    logic [31:0] tgt_rdata = 0;

    int errs = 0, checks = 0, nreq = 0, nrsp = 0, nerr = 0, lat = 0, wcnt = 0;
    bit done = 0;
    logic [31:0] last_rd = 0;

    always #4 clk = ~clk;

    cfg_window_decoder dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural target: present when bus<4 and dev<8
    always @(negedge clk) begin
        if (tgt_rsp_valid) begin
            tgt_rsp_valid <= 0;
            wcnt <= 0;
        end else if (tgt_req_valid) begin
            if (wcnt >= lat) begin
                tgt_rsp_valid <= 1;
                tgt_present   <= (tgt_bus < 4) && (tgt_dev < 8);
                tgt_rdata     <= {3'b101, tgt_bus, tgt_dev, tgt_fn, tgt_reg};
            end else wcnt <= wcnt + 1;
        end
    end

    // reference model
    int m_st = 0;
    bit m_mapped = 0, m_err = 0, m_we = 0;
    longint unsigned m_base = 0, m_size = 0;
    longint unsigned m_bus, m_dev, m_fn, m_reg, m_len, m_wd;
    logic [31:0] m_rd = 0;

    function automatic bit legal_size(longint unsigned s);
        for (int k = 20; k <= 28; k++) if (s == (64'd1 << k)) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_mapped = 0; m_err = 0;
        end else begin
            if (m_st == 2) m_st = 0;
            else if (m_st == 1) begin
                if (tgt_rsp_valid) begin
                    m_st = 2;
                    m_rd = m_we ? 32'h0 : (tgt_present ? tgt_rdata : 32'hFFFF_FFFF);
                end
            end else if (cpu_req && m_mapped && (cpu_len == 1 || cpu_len == 2 || cpu_len == 4)
                         && cpu_addr >= m_base && cpu_addr < m_base + m_size) begin
                longint unsigned off;
                off   = cpu_addr - m_base;
                m_st  = 1;
                m_we  = cpu_we;
                m_reg = off % 4096;
                m_fn  = (off / 4096) % 8;
                m_dev = (off / 32768) % 32;
                m_bus = (off / 1048576) % 512;
                m_len = cpu_len;
                m_wd  = cpu_wdata;
            end
            m_err = 0;
            if (map_upd) begin
                m_mapped = 0;
                if (map_en) begin
                    if (legal_size(map_size)) begin
                        m_mapped = 1; m_base = map_base; m_size = map_size;
                    end else m_err = 1;
                end
            end
        end
        #1;
        if (rst_n) begin
            if ($rose(tgt_req_valid)) nreq++;
            if (cpu_rsp_valid) begin nrsp++; last_rd = cpu_rdata; end
            if (map_err) nerr++;
        end
        chk(cpu_ready == (m_st == 0), "R12 ready", cpu_ready, m_st == 0);
        chk(tgt_req_valid == (m_st == 1), "R12 req", tgt_req_valid, m_st == 1);
        chk(cpu_rsp_valid == (m_st == 2), "R12 rsp", cpu_rsp_valid, m_st == 2);
        chk(win_mapped == m_mapped, "R11 mapped", win_mapped, m_mapped);
        chk(map_err == m_err, "R10 err", map_err, m_err);
        if (m_st == 2) chk(cpu_rdata == m_rd, m_we ? "R7 wdata" : "R6 rdata", cpu_rdata, m_rd);
        if (m_st == 1) begin
            chk(tgt_reg == m_reg, "R2 reg", tgt_reg, m_reg);
            chk(tgt_dev == m_dev && tgt_fn == m_fn, "R3 devfn", {tgt_dev, tgt_fn}, {m_dev[4:0], m_fn[2:0]});
            chk(tgt_bus == m_bus, "R4 bus", tgt_bus, m_bus);
            chk(tgt_len == m_len, "R5 len", tgt_len, m_len);
            chk(tgt_we == m_we && tgt_wdata == m_wd, "R12 write fields", tgt_wdata, m_wd);
        end
    end

    task automatic do_map(input bit en, input logic [31:0] b, input logic [31:0] s);
        @(negedge clk);
        map_upd = 1; map_en = en; map_base = b; map_size = s;
        @(negedge clk);
        map_upd = 0;
        @(negedge clk);
    endtask

    task automatic access(input bit we, input logic [31:0] a, input logic [2:0] len,
                          input bit claimed, input string req, input logic [31:0] exp_rd);
        int r0, s0;
        r0 = nreq; s0 = nrsp;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_len = len; cpu_wdata = a ^ 32'h5A5A_0000;
        @(negedge clk);
        cpu_req = 0;
        repeat (8) @(negedge clk);
        if (claimed) begin
            chk(nrsp == s0 + 1, req, nrsp - s0, 1);
            chk(last_rd == exp_rd, req, last_rd, exp_rd);
        end else begin
            chk(nreq == r0 && nrsp == s0, req, nreq - r0 + nrsp - s0, 0);
        end
        lat = (lat + 1) % 4;
    endtask

    function automatic logic [31:0] pdata(logic [31:0] off);
        return {3'b101, off[28:0]};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!win_mapped && cpu_ready && !tgt_req_valid && !cpu_rsp_valid && !map_err,
            "R1 reset state", {win_mapped, cpu_ready, tgt_req_valid, cpu_rsp_valid}, 4'b0100);

        access(0, 32'hE000_0000, 4, 0, "R8 unmapped read", 0);

        do_map(1, 32'hE000_0000, 32'h0008_0000);
        do_map(1, 32'hE000_0000, 32'h2000_0000);
        do_map(1, 32'hE000_0000, 32'h0030_0000);
        do_map(1, 32'hE000_0000, 32'h0);
        chk(nerr == 4 && !win_mapped, "R10 illegal sizes", nerr, 4);

        do_map(1, 32'hE000_0000, 32'h1000_0000);
        chk(win_mapped, "R11 map", win_mapped, 1);
        access(0, 32'hE000_0000 + {9'd2, 5'd3, 3'd5, 12'h0A4}, 4, 1, "R3 present read",
               pdata({9'd2, 5'd3, 3'd5, 12'h0A4}));
        access(0, 32'hE000_0000 + {9'd1, 5'd7, 3'd7, 12'hFFF}, 1, 1, "R2 byte read",
               pdata({9'd1, 5'd7, 3'd7, 12'hFFF}));
        access(0, 32'hE000_0000 + {9'd3, 5'd0, 3'd1, 12'h010}, 2, 1, "R5 half read",
               pdata({9'd3, 5'd0, 3'd1, 12'h010}));
        access(0, 32'hE000_0000 + {9'd200, 5'd1, 3'd0, 12'h000}, 4, 1, "R6 absent bus", 32'hFFFF_FFFF);
        access(0, 32'hE000_0000 + {9'd0, 5'd31, 3'd2, 12'h004}, 4, 1, "R6 absent dev", 32'hFFFF_FFFF);
        access(1, 32'hE000_0000 + {9'd255, 5'd20, 3'd0, 12'h008}, 4, 1, "R7 absent write", 0);
        chk(win_mapped, "R7 window kept", win_mapped, 1);
        access(1, 32'hE000_0000 + {9'd1, 5'd1, 3'd1, 12'h100}, 2, 1, "R12 present write", 0);
        access(0, 32'hE000_0000 + {9'd1, 5'd1, 3'd1, 12'h100}, 3, 0, "R5 width 3 dropped", 0);
        access(0, 32'hE000_0000 + {9'd1, 5'd1, 3'd1, 12'h100}, 0, 0, "R5 width 0 dropped", 0);
        access(0, 32'hDFFF_FFFC, 4, 0, "R9 below base", 0);
        access(0, 32'hF000_0000, 4, 0, "R9 above top", 0);
        access(0, 32'hEFFF_FFFC, 4, 1, "R4 last word", 32'hFFFF_FFFF);

        do_map(1, 32'h4000_0000, 32'h0010_0000);
        access(0, 32'hE000_0000, 4, 0, "R11 old window gone", 0);
        access(0, 32'h4000_0000 + {5'd2, 3'd4, 12'h03C}, 4, 1, "R4 small window",
               pdata({9'd0, 5'd2, 3'd4, 12'h03C}));
        access(0, 32'h4010_0000, 4, 0, "R9 one past small", 0);

        do_map(0, 32'h4000_0000, 32'h0010_0000);
        chk(!win_mapped, "R11 disable", win_mapped, 0);
        access(0, 32'h4000_0000, 4, 0, "R8 after disable", 0);

        do_map(1, 32'h4000_0000, 32'h0010_0000);
        do_map(1, 32'h8000_0000, 32'h0020_0001);
        chk(nerr == 5 && !win_mapped, "R10 bad size unmaps", nerr, 5);
        access(0, 32'h4000_0000, 4, 0, "R10 no window after error", 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++; checks++;
            $display("FAIL R12 watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule